// File: doc/BRIEF.md
# Ethernet PHY Power-Up Reset Sequencer

This block sits on the host or MAC side of an Ethernet PHY and runs the bring-up that the PHY needs on first power-up. It holds the PHY's active-low reset pin low, releases it, and waits. It then sends one management write that puts 0x4040 into the PHY's basic control register (register 0). After a longer wait it pulses the reset pin low a second time. When the pin is released for good, the block raises a ready flag, and from that point the PHY can be configured in the normal way.

The management write is a single Clause 22 MDIO write frame, driven on MDC, MDIO and an output enable for MDIO. Every wait, both hold times and the MDC half-period are counted in system clocks and set by parameters, so a simulation can use short values while silicon uses the real millisecond figures. The sequence starts by itself when the block leaves reset. A start pulse given after completion runs the whole sequence again.

Top module: `phy_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `phy_rst_n`, `done`, `mdc` and `mdio_oe` are all 0 and `mdio_o` is 1.
- R2: After `rst_n` is released, `phy_rst_n` stays low for exactly `HOLD1_CYC` clock cycles and then goes high.
- R3: After the first release there are exactly `WAIT1_CYC` cycles with `phy_rst_n` high and the MDIO port idle (`mdio_oe`=0, `mdc`=0) before the frame begins.
- R4: The frame is 64 bits, sent from bit 63 down to bit 0, in this order: 32 ones, start `01`, write opcode `01`, 5-bit PHY address (`PHY_ADDR`, MSB first), 5-bit register number `00000`, turnaround `10`, then the 16-bit value 0x4040, MSB first.
- R5: During the frame, MDC starts low and toggles every `CLK_DIV` clocks, so each bit takes `2*CLK_DIV` clocks. `mdio_o` changes only on a falling MDC edge. The frame lasts exactly `128*CLK_DIV` cycles and leaves MDC low.
- R6: After the frame there are exactly `WAIT2_CYC` cycles with `phy_rst_n` high and the MDIO port idle.
- R7: `phy_rst_n` is then driven low for exactly `HOLD2_CYC` cycles and is then released high.
- R8: `done` rises one cycle after the final release of `phy_rst_n`. It stays high, with `phy_rst_n` high, until a new run begins.
- R9: A `start` pulse while `done` is high begins a new run. In the next cycle `done` is 0 and `phy_rst_n` is low, and the run follows the same timing as R2 to R8.
- R10: `start` has no effect while a run is in progress. This includes a `start` held high across the beginning of a new run.
- R11: `mdio_oe` is 1 for the whole frame and only then. Whenever `mdio_oe` is 0, `mdio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| start | input | 1 | Request to re-run the sequence, honoured only after completion |
| phy_rst_n | output | 1 | Active-low reset pin of the PHY |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven towards the PHY |
| mdio_oe | output | 1 | Output enable for the management data pad |
| done | output | 1 | PHY released and ready for configuration |

## Verification
The bench compares every output on every cycle against a model that works out the expected pin levels from the number of cycles since the run began. It does this with segment boundaries and closed-form arithmetic. An uninterrupted power-up run checks the order and exact length of every phase and each bit of the frame against MDC. `start` pulses are placed in each busy phase (first hold, pre-write wait, mid-frame, post-write wait, second hold and the settle cycle), so a controller that reacts early can be told apart from one that ignores them. A re-run from the completed state, a reset in the middle of the frame, and a `start` held across the beginning of a new run separate proper restarting from restarting more than once.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

   localparam int FRAME_W = 64;

   typedef enum logic [2:0] {
      ST_HOLD1  = 3'd0,
      ST_WAIT1  = 3'd1,
      ST_WRITE  = 3'd2,
      ST_WAIT2  = 3'd3,
      ST_HOLD2  = 3'd4,
      ST_SETTLE = 3'd5,
      ST_DONE   = 3'd6
   } seq_state_e;

   // Clause 22 write: preamble, start, opcode, phy, reg, turnaround, data
   function automatic logic [FRAME_W-1:0] c22_write_frame(
      input logic [4:0]  phy,
      input logic [4:0]  regn,
      input logic [15:0] val
   );
      return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, regn, 2'b10, val};
   endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] len,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   assign last = (cnt_q == (len - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (!last) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("phy_seq_timer: CNT_W must be at least 1");
      end
   endgenerate

   // R2: the count never runs past the programmed length
   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (len != '0) |-> (cnt_q < len) || restart || $changed(len));

endmodule

// File: rtl/phy_mdio_wr.sv
module phy_mdio_wr #(
   parameter int CLK_DIV = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                go,
   input  logic [phy_bringup_pkg::FRAME_W-1:0] frame,
   output logic                                mdc,
   output logic                                mdio_o,
   output logic                                mdio_oe,
   output logic                                fin
);
   import phy_bringup_pkg::*;

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BIT_W = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   logic               busy_q;
   logic               mdc_q;
   logic [BIT_W-1:0]   bit_q;
   logic [FRAME_W-1:0] sh_q;
   logic               div_last;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("phy_mdio_wr: CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_div_one
         assign div_last = 1'b1;
      end else begin : g_div_cnt
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!busy_q || div_last) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
         assign div_last = (div_q == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mdc_q  <= 1'b0;
         bit_q  <= '0;
         sh_q   <= '1;
      end else if (!busy_q) begin
         if (go) begin
            busy_q <= 1'b1;
            mdc_q  <= 1'b0;
            bit_q  <= '0;
            sh_q   <= frame;
         end
      end else if (div_last) begin
         mdc_q <= ~mdc_q;
         if (mdc_q) begin
            if (bit_q == LAST_BIT) begin
               busy_q <= 1'b0;
            end else begin
               sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
               bit_q <= bit_q + BIT_W'(1);
            end
         end
      end
   end

   assign fin     = busy_q && div_last && mdc_q && (bit_q == LAST_BIT);
   assign mdc     = mdc_q;
   assign mdio_oe = busy_q;
   assign mdio_o  = busy_q ? sh_q[FRAME_W-1] : 1'b1;

   // R5: data moves only together with a falling MDC edge
   a_r5_data_on_mdc_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

   // R5: MDC is parked low whenever the port is idle
   a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !mdio_oe |-> !mdc);

   // R11: idle data line reads as one
   a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !mdio_oe |-> mdio_o);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
   parameter int          CLK_DIV   = 4,
   parameter int          HOLD1_CYC = 2_000,
   parameter int          WAIT1_CYC = 25_000_000,
   parameter int          WAIT2_CYC = 100_000_000,
   parameter int          HOLD2_CYC = 5_000_000,
   parameter int          PHY_ADDR  = 0,
   parameter logic [15:0] CTRL_VAL  = 16'h4040
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic phy_rst_n,
   output logic mdc,
   output logic mdio_o,
   output logic mdio_oe,
   output logic done
);
   import phy_bringup_pkg::*;

   localparam int MAX_A   = (HOLD1_CYC > WAIT1_CYC) ? HOLD1_CYC : WAIT1_CYC;
   localparam int MAX_B   = (HOLD2_CYC > WAIT2_CYC) ? HOLD2_CYC : WAIT2_CYC;
   localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam logic [FRAME_W-1:0] FRAME =
      c22_write_frame(5'(PHY_ADDR), 5'd0, CTRL_VAL);

   generate
      if (HOLD1_CYC < 1 || WAIT1_CYC < 1 || WAIT2_CYC < 1 || HOLD2_CYC < 1)
      begin : g_bad_delay
         $error("phy_bringup_seq: every delay must be at least one cycle");
      end
      if (PHY_ADDR < 0 || PHY_ADDR > 31) begin : g_bad_addr
         $error("phy_bringup_seq: PHY_ADDR must fit in five bits");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] tlen;
   logic             t_last;
   logic             wr_go;
   logic             wr_fin;
   logic             prst_n_q;
   logic             done_q;

   always_comb begin
      state_d = state_q;
      tlen    = CNT_W'(1);
      unique case (state_q)
         ST_HOLD1: begin
            tlen = CNT_W'(HOLD1_CYC);
            if (t_last) state_d = ST_WAIT1;
         end
         ST_WAIT1: begin
            tlen = CNT_W'(WAIT1_CYC);
            if (t_last) state_d = ST_WRITE;
         end
         ST_WRITE: begin
            if (wr_fin) state_d = ST_WAIT2;
         end
         ST_WAIT2: begin
            tlen = CNT_W'(WAIT2_CYC);
            if (t_last) state_d = ST_HOLD2;
         end
         ST_HOLD2: begin
            tlen = CNT_W'(HOLD2_CYC);
            if (t_last) state_d = ST_SETTLE;
         end
         ST_SETTLE: state_d = ST_DONE;
         ST_DONE: begin
            if (start) state_d = ST_HOLD1;
         end
         default: state_d = ST_HOLD1;
      endcase
   end

   assign wr_go = (state_q == ST_WAIT1) && t_last;

   phy_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_d != state_q),
      .len     (tlen),
      .last    (t_last)
   );

   phy_mdio_wr #(.CLK_DIV(CLK_DIV)) u_mdio (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (wr_go),
      .frame   (FRAME),
      .mdc     (mdc),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .fin     (wr_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_HOLD1;
         prst_n_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         prst_n_q <= !((state_d == ST_HOLD1) || (state_d == ST_HOLD2));
         done_q   <= (state_d == ST_DONE);
      end
   end

   assign phy_rst_n = prst_n_q;
   assign done      = done_q;

   // R11: the management port is driven only while the write phase runs
   a_r11_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> (state_q == ST_WRITE));

   // R8: ready rises only after the reset pin has already been high a cycle
   a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (phy_rst_n && $past(phy_rst_n)));

   // R7: reset pin low throughout the second hold
   a_r7_hold2_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD2) |-> !phy_rst_n);

   // R10: a request during a busy phase does not restart the sequence
   a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != ST_DONE && state_q != ST_HOLD1) |=> (state_q != ST_HOLD1));

endmodule

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;

   localparam int D  = 2;
   localparam int H1 = 5;
   localparam int W1 = 7;
   localparam int W2 = 9;
   localparam int H2 = 4;
   localparam logic [4:0] PA = 5'h13;
   localparam int E1 = H1;
   localparam int E2 = E1 + W1;
   localparam int E3 = E2 + 128 * D;
   localparam int E4 = E3 + W2;
   localparam int E5 = E4 + H2;
   localparam int E6 = E5 + 1;
   localparam logic [63:0] FRAME =
      {32'hFFFF_FFFF, 2'b01, 2'b01, PA, 5'b00000, 2'b10, 16'h4040};

   logic clk = 1'b0;
   logic rst_n;
   logic start;
   logic phy_rst_n, mdc, mdio_o, mdio_oe, done;

   int m_t = 0;
   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ign_until = 0;
   int run_no = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   phy_bringup_seq #(
      .CLK_DIV(D), .HOLD1_CYC(H1), .WAIT1_CYC(W1),
      .WAIT2_CYC(W2), .HOLD2_CYC(H2), .PHY_ADDR(int'(PA)), .CTRL_VAL(16'h4040)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .phy_rst_n(phy_rst_n), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .done(done)
   );

   // reference: cycles elapsed since the current run began
   always @(posedge clk) begin
      if (!rst_n)                m_t <= 0;
      else if (m_t >= E6 && start) m_t <= 0;
      else if (m_t < E6)         m_t <= m_t + 1;
   end

   task automatic chk(input string tag, input string sig, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s t=%0d cyc=%0d got %b expected %b", tag, sig, m_t, cyc, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         logic e_rst, e_mdc, e_oe, e_mdo, e_done;
         string tag;
         string tag_mdc;
         string tag_mdo;
         int w;
         cyc++;
         e_mdc = 1'b0; e_oe = 1'b0; e_mdo = 1'b1; e_done = 1'b0; e_rst = 1'b1;
         tag_mdc = "R3"; tag_mdo = "R11";
         if (m_t < E1) begin
            e_rst = 1'b0; tag = (run_no > 0) ? "R9" : "R2";
         end else if (m_t < E2) begin
            tag = "R3";
         end else if (m_t < E3) begin
            w = m_t - E2;
            e_oe = 1'b1;
            e_mdc = ((w / D) % 2) == 1;
            e_mdo = FRAME[63 - (w / (2 * D))];
            tag = "R4"; tag_mdc = "R5"; tag_mdo = "R4";
         end else if (m_t < E4) begin
            tag = "R6"; tag_mdc = "R6";
         end else if (m_t < E5) begin
            e_rst = 1'b0; tag = "R7"; tag_mdc = "R7";
         end else if (m_t < E6) begin
            tag = "R8"; tag_mdc = "R8";
         end else begin
            e_done = 1'b1; tag = "R8"; tag_mdc = "R8";
         end
         if (cyc < ign_until) tag = "R10";
         if (!rst_n) begin
            tag = "R1"; tag_mdc = "R1"; tag_mdo = "R1";
         end
         chk(tag, "phy_rst_n", phy_rst_n, e_rst);
         chk(tag, "done", done, e_done);
         chk(tag_mdc, "mdc", mdc, e_mdc);
         chk(rst_n ? "R11" : "R1", "mdio_oe", mdio_oe, e_oe);
         chk(tag_mdo, "mdio_o", mdio_o, e_mdo);
         if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   task automatic wait_t(input int x);
      while (m_t != x) @(negedge clk);
   endtask

   // R10: pulse start at a chosen point of a busy run
   task automatic pulse_at(input int x);
      wait_t(x);
      start = 1'b1;
      ign_until = cyc + 8;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);               // R1 reset state
      rst_n = 1'b1;
      pulse_at(2);                             // R10 during first hold
      pulse_at(E1 + 2);                        // R10 during pre-write wait
      pulse_at(E2 + 37);                       // R10 mid frame
      pulse_at(E3 + 1);                        // R10 after frame
      pulse_at(E4 + 1);                        // R10 during second hold
      pulse_at(E5);                            // R10 in settle cycle
      wait_t(E6);
      repeat (5) @(negedge clk);               // R8 done stays high
      run_no = 1;
      start = 1'b1;                            // R9 re-run
      @(negedge clk);
      start = 1'b0;
      wait_t(E2 + 50);                         // reset in the middle of the frame
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wait_t(E6);
      repeat (3) @(negedge clk);
      start = 1'b1;                            // R10 start held over a new run
      ign_until = cyc + 8;
      repeat (3) @(negedge clk);
      start = 1'b0;
      wait_t(E6);
      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule